// File: doc/BRIEF.md
# Multi-Mode Inversion Link Encoder

This block sits between a network interface and a point-to-point link of an on-chip network. For each body flit it picks one of four encodings before the word is driven onto the wires: the word as is, the word with its odd-indexed bits complemented, the word with its even-indexed bits complemented, or the fully complemented word. The goal is to cut the weighted coupling activity between neighbouring wires, measured against the word that was last driven. A 2-bit mode travels beside the data on sideband lines. The receiving side applies the same mask again to recover the payload, because each of the three masks undoes itself.

The choice is made in three stages. A bank of per-pair detectors looks at each pair of adjacent lines. Four ones-counters total the detector outputs. A decision stage then applies three closed-form inequality tests. Header flits skip the choice and go out unchanged. The encoded word and mode are registered, so the word on the link is also the reference for the next decision. The decoder is a purely combinational path on its own port pair.

Top module: `xinv_link_codec`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears `link_valid`, `link_head`, `link_mode` and `link_data` to zero. The reference word is therefore zero after reset.
- R2: A flit accepted with `in_valid` high at an edge appears on the link outputs at that same edge, and `link_valid` goes high. After an edge with `in_valid` low, `link_valid` is low and `link_data` and `link_mode` keep their values.
- R3: A flit with `in_head` high is sent with `link_mode` = 2'b00 and `link_data` equal to `in_data`, whatever the detector counts are.
- R4: Mode codes and masks (bit 0 is the LSB): 2'b00 means no change, 2'b10 complements bits 1,3,5,…, 2'b01 complements bits 0,2,4,…, and 2'b11 complements every bit. `link_data` = `in_data` XOR the mask of the chosen mode.
- R5: Pair i is formed by bits i and i+1 of the reference word (old) and of `in_data` (new). A pair is Type I if one line toggles, Type II if both toggle in opposite directions, Type III if both toggle in the same direction, and Type IV if neither toggles. Four counts are taken over all W-1 pairs:
  - Ty counts pairs that are Type II, or Type I and not turned into Type II by the odd mask.
  - Te counts the same for the even mask.
  - T2 counts Type II pairs.
  - T4xx counts Type IV pairs whose full complement would be Type II, which happens when the two bits differ.
- R6: With N = W-1 and D = 2(T2-T4xx), a body flit uses the full mode when D > 2Ty-N, T2 > T4xx and D > 2Te-N all hold. This test has the highest priority.
- R7: If the full test fails, the even mode is used when 2Te > N, Te > Ty and D < 2Te-N all hold.
- R8: If the full and even tests fail, the odd mode is used when D < 2Ty-N, 2Ty > N and Te < Ty all hold.
- R9: A body flit for which none of the three tests holds is sent with mode 2'b00 and unchanged data. A tie such as Te = Ty falls into this case.
- R10: `rx_out` = `rx_data` XOR the mask of `rx_mode` (same masks as R4), combinationally. Feeding the link outputs back in returns the original `in_data`.
- R11: Every sent flit, header or body, becomes the reference word for the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A flit is offered this cycle |
| in_head | input | 1 | The offered flit is a header (bypasses encoding) |
| in_data | input | W | Raw flit payload |
| link_valid | output | 1 | Link word valid |
| link_head | output | 1 | Link word is a header |
| link_mode | output | 2 | Sideband encoding mode |
| link_data | output | W | Encoded word on the link |
| rx_mode | input | 2 | Received sideband mode |
| rx_data | input | W | Received encoded word |
| rx_out | output | W | Decoded payload |

## Verification
The hardest thing to reach from the ports is a chosen reference word paired with a chosen new word. Only such pairs make each inequality hold alone, tie, or lose to a T4xx-heavy word, and the reference is normally set by the encoder's own previous decision. The stimulus uses header flits, which pass unchanged, to load any reference it wants. It also steers body flits whose encoded form keeps the link at a fixed pattern (0x55), so that the odd, even, full and tie cases can be entered one after another. A long random run with occasional headers, compared against a pair-classifying model, then covers the mixed counts where several tests compete.

// File: rtl/xinv_pkg.sv
// Shared types for the multi-mode inversion link encoder.
// Assumes: mode bit 1 selects odd-bit complement and bit 0 selects
// even-bit complement, so full inversion is both bits set.
package xinv_pkg;

    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_EVEN = 2'b01,
        MODE_ODD  = 2'b10,
        MODE_FULL = 2'b11
    } xinv_mode_e;

endpackage

// File: rtl/xinv_pair_bank.sv
// Per-pair transition detectors. For each adjacent pair (i, i+1) this
// module compares the reference word with the new word and raises four
// flags: ty (odd mask helps or stays neutral), te (even mask likewise),
// t2 (opposite-direction toggle), t4xx (idle pair that a full complement
// would turn into an opposite toggle).
// Assumes W >= 2; pair i owns bits i and i+1.
module xinv_pair_bank #(
    parameter int W = 8,
    localparam int NP = W - 1
) (
    input  logic [W-1:0]  ref_word,
    input  logic [W-1:0]  new_word,
    output logic [NP-1:0] ty_v,
    output logic [NP-1:0] te_v,
    output logic [NP-1:0] t2_v,
    output logic [NP-1:0] t4xx_v
);

    for (genvar i = 0; i < NP; i++) begin : g_pair
        logic tog_lo, tog_hi, ref_diff;
        logic is_t1, is_t2, is_t4;
        logic odd_to_t2, even_to_t2;

        // classify the pair transition
        always_comb begin
            tog_lo   = ref_word[i] ^ new_word[i];
            tog_hi   = ref_word[i+1] ^ new_word[i+1];
            ref_diff = ref_word[i] ^ ref_word[i+1];
            is_t1    = tog_lo ^ tog_hi;
            is_t2    = tog_lo & tog_hi & ref_diff;
            is_t4    = ~tog_lo & ~tog_hi;
        end

        // a single-line toggle becomes an opposite toggle when the mask
        // hits the idle line and the lines started out different
        if ((i % 2) == 0) begin : g_even_lo
            // low line is even, high line is odd
            always_comb begin
                odd_to_t2  = is_t1 & ref_diff & tog_lo;
                even_to_t2 = is_t1 & ref_diff & tog_hi;
            end
        end else begin : g_odd_lo
            // low line is odd, high line is even
            always_comb begin
                odd_to_t2  = is_t1 & ref_diff & tog_hi;
                even_to_t2 = is_t1 & ref_diff & tog_lo;
            end
        end

        // drive the four flag vectors
        always_comb begin
            ty_v[i]   = is_t2 | (is_t1 & ~odd_to_t2);
            te_v[i]   = is_t2 | (is_t1 & ~even_to_t2);
            t2_v[i]   = is_t2;
            t4xx_v[i] = is_t4 & ref_diff;
        end
    end

endmodule

// File: rtl/xinv_ones.sv
// Ones counter: returns the number of set bits of a flag vector.
// Assumes CW bits can hold N (caller sizes CW = clog2(N+1) or more).
module xinv_ones #(
    parameter int N  = 7,
    parameter int CW = 3
) (
    input  logic [N-1:0]  flags,
    output logic [CW-1:0] count
);

    // accumulate set bits
    always_comb begin
        count = '0;
        for (int k = 0; k < N; k++) begin
            count = count + CW'(flags[k]);
        end
    end

endmodule

// File: rtl/xinv_mode_pick.sv
// Decision stage: evaluates the full, even and odd inequality sets on
// the four pair counts and returns the mode. Priority is full, then
// even, then odd; none when no set holds.
// Assumes counts are unsigned and NP = number of pairs.
module xinv_mode_pick
    import xinv_pkg::*;
#(
    parameter int NP = 7,
    parameter int CW = 3
) (
    input  logic [CW-1:0] cnt_ty,
    input  logic [CW-1:0] cnt_te,
    input  logic [CW-1:0] cnt_t2,
    input  logic [CW-1:0] cnt_t4xx,
    output xinv_mode_e    mode
);

    int ty_s, te_s, t2_s, t4_s, diff2;
    logic full_ok, even_ok, odd_ok;

    // widen counts to signed integers
    always_comb begin
        ty_s  = int'(cnt_ty);
        te_s  = int'(cnt_te);
        t2_s  = int'(cnt_t2);
        t4_s  = int'(cnt_t4xx);
        diff2 = 2 * (t2_s - t4_s);
    end

    // the three inequality sets
    always_comb begin
        full_ok = (diff2 > 2 * ty_s - NP) && (t2_s > t4_s) &&
                  (diff2 > 2 * te_s - NP);
        even_ok = (2 * te_s > NP) && (te_s > ty_s) &&
                  (diff2 < 2 * te_s - NP);
        odd_ok  = (diff2 < 2 * ty_s - NP) && (2 * ty_s > NP) &&
                  (te_s < ty_s);
    end

    // priority resolve
    always_comb begin
        if (full_ok)      mode = MODE_FULL;
        else if (even_ok) mode = MODE_EVEN;
        else if (odd_ok)  mode = MODE_ODD;
        else              mode = MODE_NONE;
    end

endmodule

// File: rtl/xinv_mask_apply.sv
// Applies a mode mask: mode bit 1 complements odd-indexed bits, mode
// bit 0 complements even-indexed bits. Being an XOR, it serves both
// encode and decode.
module xinv_mask_apply #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    input  logic [1:0]   mode,
    output logic [W-1:0] dout
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        // pick the mode bit that governs this lane
        if ((b % 2) == 1) begin : g_odd
            assign dout[b] = din[b] ^ mode[1];
        end else begin : g_even
            assign dout[b] = din[b] ^ mode[0];
        end
    end

endmodule

// File: rtl/xinv_link_codec.sv
// Multi-mode inversion link encoder with its matching decoder.
// The encoder compares each body flit with the word last driven on the
// link, chooses none/odd/even/full inversion, and registers the encoded
// word with its 2-bit mode. Headers pass with mode 00. The decoder is a
// combinational mask on the rx port pair.
// Assumes W >= 2; synchronous active-low reset.
module xinv_link_codec
    import xinv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_head,
    input  logic [W-1:0] in_data,
    output logic         link_valid,
    output logic         link_head,
    output logic [1:0]   link_mode,
    output logic [W-1:0] link_data,
    input  logic [1:0]   rx_mode,
    input  logic [W-1:0] rx_data,
    output logic [W-1:0] rx_out
);

    localparam int NP = W - 1;
    localparam int CW = $clog2(W);

    logic [NP-1:0] ty_v, te_v, t2_v, t4xx_v;
    logic [CW-1:0] cnt_ty, cnt_te, cnt_t2, cnt_t4xx;
    xinv_mode_e    picked;
    logic [1:0]    use_mode;
    logic [W-1:0]  enc_word;

    xinv_pair_bank #(.W(W)) u_pairs (
        .ref_word (link_data),
        .new_word (in_data),
        .ty_v     (ty_v),
        .te_v     (te_v),
        .t2_v     (t2_v),
        .t4xx_v   (t4xx_v)
    );

    xinv_ones #(.N(NP), .CW(CW)) u_cnt_ty   (.flags(ty_v),   .count(cnt_ty));
    xinv_ones #(.N(NP), .CW(CW)) u_cnt_te   (.flags(te_v),   .count(cnt_te));
    xinv_ones #(.N(NP), .CW(CW)) u_cnt_t2   (.flags(t2_v),   .count(cnt_t2));
    xinv_ones #(.N(NP), .CW(CW)) u_cnt_t4xx (.flags(t4xx_v), .count(cnt_t4xx));

    xinv_mode_pick #(.NP(NP), .CW(CW)) u_pick (
        .cnt_ty   (cnt_ty),
        .cnt_te   (cnt_te),
        .cnt_t2   (cnt_t2),
        .cnt_t4xx (cnt_t4xx),
        .mode     (picked)
    );

    // headers bypass the decision
    always_comb begin
        use_mode = in_head ? 2'b00 : picked;
    end

    xinv_mask_apply #(.W(W)) u_enc (
        .din  (in_data),
        .mode (use_mode),
        .dout (enc_word)
    );

    // link register; also holds the reference word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_valid <= 1'b0;
            link_head  <= 1'b0;
            link_mode  <= 2'b00;
            link_data  <= '0;
        end else begin
            link_valid <= in_valid;
            if (in_valid) begin
                link_head <= in_head;
                link_mode <= use_mode;
                link_data <= enc_word;
            end
        end
    end

    xinv_mask_apply #(.W(W)) u_dec (
        .din  (rx_data),
        .mode (rx_mode),
        .dout (rx_out)
    );

endmodule

// File: rtl/xinv_link_checker.sv
// Property checker for xinv_link_codec, attached with bind.
// Assumes the pair counts of the encoder are brought in as inputs.
module xinv_link_checker #(
    parameter int W  = 8,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_head,
    input logic [W-1:0]  in_data,
    input logic          link_valid,
    input logic [1:0]    link_mode,
    input logic [W-1:0]  link_data,
    input logic [CW-1:0] cnt_t2,
    input logic [CW-1:0] cnt_t4xx
);

    logic [W-1:0] chk_mask;

    // mask implied by the mode currently on the link
    always_comb begin
        for (int b = 0; b < W; b++) begin
            chk_mask[b] = ((b % 2) == 1) ? link_mode[1] : link_mode[0];
        end
    end

    // R2: an accepted flit shows up as valid next cycle
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> link_valid);

    // R2: an idle cycle leaves the link word and mode held
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!link_valid && $stable(link_data) && $stable(link_mode)));

    // R3: headers pass unchanged with mode 00
    assert_head_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_head) |=> (link_mode == 2'b00 && link_data == $past(in_data)));

    // R10: the link word unmasks back to the payload
    assert_roundtrip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((link_data ^ chk_mask) == $past(in_data)));

    // R6: full mode never chosen unless T2 exceeds T4xx
    assert_full_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_head && (cnt_t2 <= cnt_t4xx)) |=> (link_mode != 2'b11));

endmodule

bind xinv_link_codec xinv_link_checker #(.W(W), .CW(CW)) u_link_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_head    (in_head),
    .in_data    (in_data),
    .link_valid (link_valid),
    .link_mode  (link_mode),
    .link_data  (link_data),
    .cnt_t2     (cnt_t2),
    .cnt_t4xx   (cnt_t4xx)
);

// File: tb/test_xinv_link_codec.sv
// Self-checking bench for xinv_link_codec at W = 8.
module test_xinv_link_codec;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_head = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       link_valid, link_head;
    logic [1:0] link_mode;
    logic [7:0] link_data;
    logic [7:0] rx_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] m_ref = 8'h00;

    always #10 clk = ~clk;

    xinv_link_codec #(.W(8)) i_xinv_link_codec (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_head    (in_head),
        .in_data    (in_data),
        .link_valid (link_valid),
        .link_head  (link_head),
        .link_mode  (link_mode),
        .link_data  (link_data),
        .rx_mode    (link_mode),
        .rx_data    (link_data),
        .rx_out     (rx_out)
    );

    typedef struct packed {
        logic       head;
        logic [7:0] data;
        logic [1:0] mode;
        logic [7:0] link;
    } vec_t;

    // walked from reset, reference starts at 0x00
    localparam vec_t VECS [9] = '{
        '{1'b0, 8'h00, 2'b00, 8'h00},  // all idle pairs: none
        '{1'b0, 8'hFF, 2'b00, 8'hFF},  // all same-direction: none
        '{1'b0, 8'h55, 2'b00, 8'h55},  // Te == Ty tie: none
        '{1'b0, 8'hFF, 2'b10, 8'h55},  // odd wins
        '{1'b0, 8'h00, 2'b01, 8'h55},  // even wins
        '{1'b0, 8'hAA, 2'b11, 8'h55},  // full wins
        '{1'b0, 8'h55, 2'b00, 8'h55},  // T4xx blocks full
        '{1'b1, 8'hAA, 2'b00, 8'hAA},  // header bypass
        '{1'b0, 8'h55, 2'b11, 8'hAA}   // reference from header
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ptype(input bit ol, input bit oh, input bit nl, input bit nh);
        bit a, b;
        a = ol ^ nl;
        b = oh ^ nh;
        if (a && b) return (nl != nh) ? 2 : 3;
        if (a || b) return 1;
        return 4;
    endfunction

    function automatic logic [7:0] mask_of(input logic [1:0] m);
        return (m[1] ? 8'hAA : 8'h00) | (m[0] ? 8'h55 : 8'h00);
    endfunction

    // behavioural model of the decision (R5-R9)
    function automatic logic [1:0] model_mode(input logic [7:0] o, input logic [7:0] n);
        int ty = 0, te = 0, t2 = 0, t4 = 0, d, np;
        logic [7:0] no, ne, nf;
        bit f, e, od;
        no = n ^ 8'hAA;
        ne = n ^ 8'h55;
        nf = ~n;
        np = 7;
        for (int i = 0; i < 7; i++) begin
            int t, to, tev, tf;
            t   = ptype(o[i], o[i+1], n[i], n[i+1]);
            to  = ptype(o[i], o[i+1], no[i], no[i+1]);
            tev = ptype(o[i], o[i+1], ne[i], ne[i+1]);
            tf  = ptype(o[i], o[i+1], nf[i], nf[i+1]);
            if (t == 2 || (t == 1 && to != 2))  ty++;
            if (t == 2 || (t == 1 && tev != 2)) te++;
            if (t == 2) t2++;
            if (t == 4 && tf == 2) t4++;
        end
        d  = 2 * (t2 - t4);
        f  = (d > 2*ty - np) && (t2 > t4) && (d > 2*te - np);
        e  = (2*te > np) && (te > ty) && (d < 2*te - np);
        od = (d < 2*ty - np) && (2*ty > np) && (te < ty);
        if (f) return 2'b11;
        if (e) return 2'b01;
        if (od) return 2'b10;
        return 2'b00;
    endfunction

    // called at a negedge, returns at the next negedge
    task automatic send(input logic h, input logic [7:0] d);
        in_valid = 1'b1;
        in_head  = h;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_ref = 8'h00;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [1:0] em;
        logic [7:0] el, d;
        logic h;
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk("R1 link_valid", 32'(link_valid), 32'd0);
        chk("R1 link_mode", 32'(link_mode), 32'd0);
        chk("R1 link_data", 32'(link_data), 32'd0);

        // table walk: R3 R4 R5 R6 R7 R8 R9 R11
        for (int v = 0; v < 9; v++) begin
            send(VECS[v].head, VECS[v].data);
            chk($sformatf("R6 R7 R8 R9 R3 mode vec%0d", v), 32'(link_mode), 32'(VECS[v].mode));
            chk($sformatf("R4 R11 link vec%0d", v), 32'(link_data), 32'(VECS[v].link));
            chk($sformatf("R10 decode vec%0d", v), 32'(rx_out), 32'(VECS[v].data));
            chk($sformatf("R2 valid vec%0d", v), 32'(link_valid), 32'd1);
            m_ref = VECS[v].link;
        end

        // R2: idle cycle holds link word and drops valid
        in_data = 8'h3C;
        @(negedge clk);
        chk("R2 idle valid", 32'(link_valid), 32'd0);
        chk("R2 idle hold data", 32'(link_data), 32'(m_ref));
        chk("R2 idle hold mode", 32'(link_mode), 32'b11);

        // random run against the model: R5 R6 R7 R8 R9 R10 R11 R3
        for (int r = 0; r < 600; r++) begin
            d = 8'($urandom);
            h = (($urandom % 8) == 0);
            em = h ? 2'b00 : model_mode(m_ref, d);
            el = d ^ mask_of(em);
            send(h, d);
            chk("R5 R6 R7 R8 R9 random mode", 32'(link_mode), 32'(em));
            chk("R4 R11 random link", 32'(link_data), 32'(el));
            chk("R10 random decode", 32'(rx_out), 32'(d));
            m_ref = el;
        end

        // R10: decoder on its own port values via a header-set pattern
        send(1'b1, 8'h0F);
        chk("R10 header decode", 32'(rx_out), 32'h0F);

        // R1: mid-run reset clears the reference word
        send(1'b1, 8'h55);
        do_reset();
        chk("R1 mid reset data", 32'(link_data), 32'd0);
        chk("R1 mid reset valid", 32'(link_valid), 32'd0);
        // from reference 0x00, 0xFF is all same-direction toggles: none
        send(1'b0, 8'hFF);
        chk("R1 R9 reference after reset", 32'(link_mode), 32'd0);
        chk("R1 link after reset", 32'(link_data), 32'hFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule